// File: doc/BRIEF.md
# Byte-Addressed SRAM Controller with Posted Write Buffer

This block sits between a simple CPU-side request bus and an on-chip memory array of 32-bit words. The bus carries byte, halfword and word reads and writes. Every write is parked in a single-entry buffer and the request finishes at once. The parked entry holds the word address, the byte lanes and the data. It is copied into the array only when the next write is accepted, and in that same cycle the buffer takes the new write. So back-to-back writes never stall.

Reads always return the newest value. The array word is merged byte by byte with the parked entry when the two addresses meet. A warm reset empties the buffer but leaves the array alone, so the last write before a reset is lost unless it was pushed out first. Software pushes it out either with a second write or with a flush pulse. The flush pulse is the dummy write done before a low-power entry.

Top module: `sram_wbuf_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `ready` is 0, `rdata` is 0 and the buffer is empty. Array contents are not changed by reset.
- R2: Each request (`req`=1) is answered by `ready`=1 in the next cycle, and a cycle without a request gives `ready`=0 in the next cycle. Writes issued on consecutive cycles are all accepted with no stall.
- R3: A write is held in the buffer and is written into the array only when a later write is accepted. In that cycle the later write becomes the held entry.
- R4: A warm reset drops the held write: after reset, reads of its location return what the array held before that write.
- R5: Writing the same value twice in a row to a location leaves that value readable after a warm reset.
- R6: A read returns the newest data. Bytes of the held entry that overlap the read word take precedence over array bytes.
- R7: A word access ignores address bits 1:0 and a halfword access ignores address bit 0, so every access uses its naturally aligned location.
- R8: `size` is encoded as 0 for byte, 1 for halfword, and 2 or 3 for word. Write data is taken from the low-order bits of `wdata` and placed little-endian: byte address offset k maps to bits 8k+7:8k of the word. Read data is returned right-justified and zero-extended.
- R9: A `flush` pulse with no write commits the held entry to the array and empties the buffer. A `flush` that comes together with a write acts as that write alone.
- R10: The read data of a read request is on `rdata` in the cycle after the request, together with `ready`, and stays there until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low warm reset |
| req | input | 1 | Request valid this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address |
| size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| wdata | input | 32 | Write data, low-order bits used |
| flush | input | 1 | Commit the held write without a new write |
| rdata | output | 32 | Right-justified read data |
| ready | output | 1 | Request completed (one cycle after `req`) |

## Verification
Every result is due exactly one clock after the request that causes it. `ready` and the read data are registered once. A buffered write becomes visible to reads in the very next request and reaches the array on the next write or flush. The bench drives each request at a falling edge and compares `ready` and, for reads, `rdata` against its byte-level model at the following falling edge. Effects that stay hidden in the array are brought out by a warm reset followed by reads.

// File: rtl/sram_wbuf_pkg.sv
package sram_wbuf_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam int         LANES   = 4;

  // Byte lanes touched by an access, little-endian within the word.
  function automatic logic [3:0] lane_mask(input logic [1:0] lo, input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 4'b0001 << lo;
      SZ_HALF: return lo[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  // Replicate the low-order write data across every lane it may occupy.
  function automatic logic [31:0] place_lanes(input logic [31:0] d, input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return {4{d[7:0]}};
      SZ_HALF: return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  // Right-justify and zero-extend the addressed part of a word.
  function automatic logic [31:0] align_read(input logic [31:0] w, input logic [1:0] lo,
                                             input logic [1:0] sz);
    logic [31:0] sh;
    sh = w >> {lo, 3'b000};
    case (sz)
      SZ_BYTE: return {24'h0, sh[7:0]};
      SZ_HALF: return {16'h0, (lo[1] ? w[31:16] : w[15:0])};
      default: return w;
    endcase
  endfunction
endpackage

// File: rtl/sram_array.sv
module sram_array #(
  parameter int WORD_AW = 6
) (
  input  logic               clk,
  input  logic               we,
  input  logic [WORD_AW-1:0] waddr,
  input  logic [3:0]         wmask,
  input  logic [31:0]        wdata,
  input  logic [WORD_AW-1:0] raddr,
  output logic [31:0]        rdata
);
  localparam int DEPTH = 1 << WORD_AW;

  logic [31:0] mem [DEPTH];

  // No reset: contents survive a warm reset.
  always_ff @(posedge clk) begin
    if (we) begin
      for (int g = 0; g < 4; g++) begin
        if (wmask[g]) mem[waddr][8*g +: 8] <= wdata[8*g +: 8];
      end
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sram_post_buf.sv
module sram_post_buf #(
  parameter int WORD_AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_req,
  input  logic [WORD_AW-1:0] wr_word,
  input  logic [3:0]         wr_mask,
  input  logic [31:0]        wr_lanes,
  input  logic               flush,
  output logic               buf_valid,
  output logic [WORD_AW-1:0] buf_word,
  output logic [3:0]         buf_mask,
  output logic [31:0]        buf_data,
  output logic               commit_we
);
  // The held entry drains on the next write or on a flush.
  assign commit_we = buf_valid && (wr_req || flush);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      buf_valid <= 1'b0;
    else if (wr_req) buf_valid <= 1'b1;
    else if (flush)  buf_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (wr_req) begin
      buf_word <= wr_word;
      buf_mask <= wr_mask;
      buf_data <= wr_lanes;
    end
  end

  a_r3_write_fills_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> buf_valid);
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !wr_req) |=> !buf_valid);
  a_r8_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> ($countones(buf_mask) == 1 || buf_mask == 4'b0011 ||
                   buf_mask == 4'b1100 || buf_mask == 4'b1111));
endmodule

// File: rtl/sram_rd_merge.sv
module sram_rd_merge
  import sram_wbuf_pkg::*;
#(
  parameter int WORD_AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_req,
  input  logic [WORD_AW-1:0] rd_word,
  input  logic [1:0]         rd_lo,
  input  logic [1:0]         rd_size,
  input  logic [31:0]        arr_data,
  input  logic               buf_valid,
  input  logic [WORD_AW-1:0] buf_word,
  input  logic [3:0]         buf_mask,
  input  logic [31:0]        buf_data,
  output logic [31:0]        rdata
);
  logic        buf_hit;
  logic [31:0] merged;

  assign buf_hit = buf_valid && (buf_word == rd_word);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[8*g +: 8] = (buf_hit && buf_mask[g]) ? buf_data[8*g +: 8]
                                                       : arr_data[8*g +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_req) rdata <= align_read(merged, rd_lo, rd_size);
  end

  a_r8_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_size == SZ_BYTE) |=> (rdata[31:8] == 24'h0));
  a_r10_hold_between_reads: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rdata));
endmodule

// File: rtl/sram_wbuf_ctrl.sv
module sram_wbuf_ctrl
  import sram_wbuf_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [31:0]       wdata,
  input  logic              flush,
  output logic [31:0]       rdata,
  output logic              ready
);
  localparam int WORD_AW = ADDR_W - 2;

  logic               wr_req, rd_req;
  logic [WORD_AW-1:0] acc_word;
  logic [1:0]         acc_lo;
  logic [31:0]        arr_rdata;
  logic               buf_valid, commit_we;
  logic [WORD_AW-1:0] buf_word;
  logic [3:0]         buf_mask;
  logic [31:0]        buf_data;

  assign wr_req   = req && we;
  assign rd_req   = req && !we;
  assign acc_word = addr[ADDR_W-1:2];
  assign acc_lo   = addr[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready <= 1'b0;
    else        ready <= req;
  end

  sram_post_buf #(.WORD_AW(WORD_AW)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (wr_req),
    .wr_word  (acc_word),
    .wr_mask  (lane_mask(acc_lo, size)),
    .wr_lanes (place_lanes(wdata, size)),
    .flush    (flush),
    .buf_valid(buf_valid),
    .buf_word (buf_word),
    .buf_mask (buf_mask),
    .buf_data (buf_data),
    .commit_we(commit_we)
  );

  sram_array #(.WORD_AW(WORD_AW)) u_arr (
    .clk  (clk),
    .we   (commit_we),
    .waddr(buf_word),
    .wmask(buf_mask),
    .wdata(buf_data),
    .raddr(acc_word),
    .rdata(arr_rdata)
  );

  sram_rd_merge #(.WORD_AW(WORD_AW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .rd_word  (acc_word),
    .rd_lo    (acc_lo),
    .rd_size  (size),
    .arr_data (arr_rdata),
    .buf_valid(buf_valid),
    .buf_word (buf_word),
    .buf_mask (buf_mask),
    .buf_data (buf_data),
    .rdata    (rdata)
  );

  a_r2_ready_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> ready);
  a_r2_idle_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !ready);
  a_r3_commit_only_on_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    commit_we |-> (wr_req || flush));
endmodule

// File: tb/tb_sram_wbuf_ctrl.sv
module tb_sram_wbuf_ctrl;
  localparam int ADDR_W = 8;
  localparam int NBYTES = 1 << ADDR_W;

  logic              clk = 0;
  logic              rst_n = 0;
  logic              req = 0, we = 0, flush = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [1:0]        size = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              ready;

  int vectors = 0;
  int errors  = 0;

  typedef struct { int a; int d; } pbyte_t;
  int     mem [NBYTES];
  pbyte_t pend [$];

  sram_wbuf_ctrl #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .size(size),
    .wdata(wdata), .flush(flush), .rdata(rdata), .ready(ready)
  );

  always #5 clk = ~clk;

  function automatic int model_byte(int a);
    for (int i = pend.size() - 1; i >= 0; i--)
      if (pend[i].a == a) return pend[i].d;
    return mem[a];
  endfunction

  function automatic void model_commit();
    foreach (pend[i]) mem[pend[i].a] = pend[i].d;
    pend.delete();
  endfunction

  task automatic step(input bit r, input bit w, input int a, input int sz,
                      input logic [31:0] d, input bit fl, input string tag);
    logic [31:0] expv;
    int n, base;
    n    = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    base = a & ~(n - 1);
    expv = '0;
    if (r && !w)
      for (int i = 0; i < n; i++) expv = expv | (32'(model_byte(base + i)) << (8 * i));
    req = r; we = w; addr = ADDR_W'(a); size = 2'(sz); wdata = d; flush = fl;
    if (r && w) begin
      model_commit();
      for (int i = 0; i < n; i++) pend.push_back('{base + i, int'((d >> (8 * i)) & 32'hFF)});
    end else if (fl) begin
      model_commit();
    end
    @(negedge clk);
    vectors++;
    if (ready !== r) begin
      errors++;
      $display("FAIL %s (R2): ready actual %b expected %b", tag, ready, r);
    end
    if (r && !w) begin
      vectors++;
      if (rdata !== expv) begin
        errors++;
        $display("FAIL %s (R10): rdata actual %h expected %h @%h sz%0d", tag, rdata, expv, a, sz);
      end
    end
    req = 0; we = 0; flush = 0;
  endtask

  task automatic warm_reset();
    req = 0; flush = 0;
    rst_n = 0;
    pend.delete();
    @(negedge clk);
    @(negedge clk);
    vectors++;
    if (ready !== 1'b0 || rdata !== 32'h0) begin
      errors++;
      $display("FAIL R1: ready/rdata actual %b/%h expected 0/00000000", ready, rdata);
    end
    rst_n = 1;
    @(negedge clk);
    vectors++;
    if (ready !== 1'b0) begin
      errors++;
      $display("FAIL R1: ready after release actual %b expected 0", ready);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    warm_reset();
    // Fill the whole array; each word written twice (R5 pattern), back to back (R2).
    for (int k = 0; k < NBYTES / 4; k++) begin
      step(1, 1, 4 * k, 2, 32'hA5000000 | k, 0, "R2 fill");
      step(1, 1, 4 * k, 2, 32'h5A000000 | k, 0, "R2 fill");
    end
    // R8: byte lanes, little-endian, read while last byte still buffered (R6).
    for (int b = 0; b < 4; b++) step(1, 1, 8'h10 + b, 0, 32'hFFFFFF00 | (8'h11 * (b + 1)), 0, "R8 wr");
    step(1, 0, 8'h10, 2, 0, 0, "R6 R8 word");
    step(1, 0, 8'h13, 0, 0, 0, "R8 byte3");
    step(1, 0, 8'h12, 1, 0, 0, "R8 half hi");
    // R7: misaligned addresses fold to the aligned location.
    step(1, 1, 8'h21, 1, 32'h0000BEEF, 0, "R7 half");
    step(1, 1, 8'h33, 2, 32'hCAFEF00D, 0, "R7 word");
    step(1, 0, 8'h20, 2, 0, 0, "R7 rd20");
    step(1, 0, 8'h31, 1, 0, 0, "R7 rd31");
    step(1, 0, 8'h30, 3, 0, 0, "R8 size3");
    // R3/R4: first write committed by second, second lost at reset.
    step(1, 1, 8'h40, 2, 32'h11112222, 0, "R3 wrA");
    step(1, 1, 8'h44, 2, 32'h33334444, 0, "R4 wrB");
    step(1, 0, 8'h44, 2, 0, 0, "R6 buffered");
    warm_reset();
    step(1, 0, 8'h40, 2, 0, 0, "R3 after reset");
    step(1, 0, 8'h44, 2, 0, 0, "R4 lost");
    // R5: double write survives reset.
    step(1, 1, 8'h48, 2, 32'h0BADC0DE, 0, "R5 w1");
    step(1, 1, 8'h48, 2, 32'h0BADC0DE, 0, "R5 w2");
    warm_reset();
    step(1, 0, 8'h48, 2, 0, 0, "R5 rd");
    // R9: flush commits without a write; flush with a read; flush alongside a write.
    step(1, 1, 8'h50, 2, 32'h13572468, 0, "R9 wr");
    step(0, 0, 0, 0, 0, 1, "R9 flush");
    step(1, 1, 8'h54, 0, 32'h0000007E, 0, "R9 wr2");
    step(1, 0, 8'h54, 0, 0, 1, "R9 flush+rd");
    step(1, 1, 8'h58, 2, 32'h99887766, 1, "R9 flush+wr");
    warm_reset();
    step(1, 0, 8'h50, 2, 0, 0, "R9 survived");
    step(1, 0, 8'h54, 2, 0, 0, "R9 flushed byte");
    step(1, 0, 8'h58, 2, 0, 0, "R9 wr held lost");
    // Idle cycle: R2 ready low.
    step(0, 0, 0, 0, 0, 0, "R2 idle");
    // Mixed random traffic (R6, R8), with occasional warm resets (R4).
    for (int t = 0; t < 3000; t++) begin
      int op;
      op = int'($urandom_range(0, 99));
      if (op < 2) warm_reset();
      else if (op < 5) step(0, 0, 0, 0, 0, 1, "R9 rnd flush");
      else if (op < 10) step(0, 0, 0, 0, 0, 0, "R2 rnd idle");
      else step(1, op < 55, int'($urandom_range(0, NBYTES - 1)), int'($urandom_range(0, 3)),
                $urandom, 0, "R6 rnd");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule